// File: doc/BRIEF.md
# Threshold-Chunk DMA Request FIFO

This block is a 64-word FIFO placed between the serializers of an audio serial port and a DMA engine. It runs in one direction at a time. In receive mode the pin side pushes received words and the DMA side drains them. In transmit mode the DMA side fills the FIFO and the pin side takes words out. The block raises a level-sensitive DMA request for every chunk of `cfg_thresh` words that has become available (receive) or free (transmit).

The request comes from a saturating count of outstanding chunks. A chunk completed on the pin side adds one to the count. A chunk completed on the DMA side subtracts one. When both happen in the same cycle the count does not change. Because of this, a completion on one side never hides a completion on the other, whether they land in the same cycle or a few cycles apart. The request is high whenever the count is nonzero.

Receive overflow and transmit underflow are held in sticky status bits. Each bit is cleared by pulsing its clear input. An invalid threshold setting is reported on a separate status pin.

Back-pressure rules:
- `pin_rx_ready` is high whenever the block is enabled in receive mode, even when the FIFO is full. The serializer is never stalled, and a word it offers while the FIFO is full is dropped.
- `dma_wr_ready` falls when the FIFO is full.
- `dma_rd_valid` and `pin_tx_valid` fall when the FIFO is empty.
- A word moves only on a cycle where its valid and ready are both high.
- In transmit mode, `pin_tx_ready` high while the FIFO is empty is an underflow.

Top module: `thr_evt_fifo`

## Requirements
- R1: While `rst_n` is low or `cfg_en` is low, the FIFO is emptied: `dma_rd_valid` and `pin_tx_valid` are low. In receive mode (`cfg_tx`=0), `dma_req` is also low.
- R2: In receive mode, each time `cfg_thresh` words have been accepted from the pin side, the outstanding count rises by one. `dma_req` is high in the cycle after the completing word and stays high while the count is nonzero.
- R3: Each time `cfg_thresh` words have moved on the DMA side, the outstanding count falls by one. `dma_req` drops after the last outstanding chunk is consumed.
- R4: A pin-side chunk completion and a DMA-side chunk completion in the same cycle leave the count unchanged. A DMA completion followed one cycle later by a pin completion leaves `dma_req` high afterwards.
- R5: In transmit mode (`cfg_tx`=1), while `cfg_en` is low the count is loaded with 64 divided by `cfg_thresh` (integer division). As a result, `dma_req` is high as soon as the block is enabled.
- R6: In transmit mode, every `cfg_thresh` words written by the DMA side subtract one from the count. Every `cfg_thresh` words read by the pin side add one.
- R7: In receive mode, a pin word offered while 64 words are held is dropped and is not counted toward a chunk. It sets `sts_ovf`, which stays set until a cycle with `sts_clr_ovf`=1. If set and clear arrive in the same cycle, set wins.
- R8: In transmit mode, `pin_tx_ready`=1 while the FIFO is empty returns `pin_tx_data`=0. It sets `sts_unf`, which stays set until a cycle with `sts_clr_unf`=1.
- R9: `sts_cfg_bad` is 1 when any of these holds: `cfg_thresh` is 0, `cfg_thresh` is above 32, `cfg_nser` is 0, or `cfg_thresh` is not a multiple of `cfg_nser`. With `cfg_thresh`=0 no chunk ever completes.
- R10: Words leave the FIFO in the order they entered it.
- R11: `pin_rx_ready` stays high while the block is enabled in receive mode. `dma_wr_ready` is low while 64 words are held. `dma_rd_valid` is low while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Enable; low clears FIFO, chunk counters and count |
| cfg_tx | input | 1 | 1 = transmit direction, 0 = receive |
| cfg_thresh | input | 8 | Words per DMA request |
| cfg_nser | input | 4 | Number of active serializers |
| pin_rx_valid | input | 1 | Received word offered by the serializer |
| pin_rx_ready | output | 1 | Receive acceptance (always high when enabled in receive mode) |
| pin_rx_data | input | 32 | Received word |
| pin_tx_valid | output | 1 | Transmit word available |
| pin_tx_ready | input | 1 | Serializer takes a transmit word |
| pin_tx_data | output | 32 | Transmit word, zero when empty |
| dma_rd_valid | output | 1 | Receive word available to the DMA |
| dma_rd_ready | input | 1 | DMA takes a receive word |
| dma_rd_data | output | 32 | Receive word to the DMA |
| dma_wr_valid | input | 1 | DMA offers a transmit word |
| dma_wr_ready | output | 1 | FIFO can take a transmit word |
| dma_wr_data | input | 32 | Transmit word from the DMA |
| dma_req | output | 1 | Level DMA request |
| sts_clr_ovf | input | 1 | Clears the overflow flag when 1 |
| sts_clr_unf | input | 1 | Clears the underflow flag when 1 |
| sts_ovf | output | 1 | Sticky receive overflow |
| sts_unf | output | 1 | Sticky transmit underflow |
| sts_cfg_bad | output | 1 | Threshold setting is invalid |

## Verification
The hardest case to reach is a pin-side chunk and a DMA-side chunk finishing on exactly the same clock edge. Reaching it needs both chunk counters one word short at the same moment, with a request already outstanding. The bench gets there by interleaving pushes and pops so that each side is three words into a four-word chunk. It then drives a push and a pop in the same cycle. It repeats the setup with the DMA completion one cycle ahead of the pin completion. In both cases it checks that the request is still high and that the words come out in their original order.

// File: rtl/tef_pkg.sv
package tef_pkg;
  // Invalid when zero, above the limit, no serializers, or not a multiple.
  function automatic logic thr_invalid(input logic [7:0] thr, input logic [3:0] nser,
                                       input int unsigned max_thr);
    logic bad;
    bad = (thr == 8'd0) || (32'(thr) > max_thr) || (nser == 4'd0);
    if (!bad && ((thr % {4'd0, nser}) != 8'd0)) bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/tef_store.sv
module tef_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/tef_chunk.sv
module tef_chunk #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] thr,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = step && (thr != '0) && (({1'b0, cnt} + 1'b1) == {1'b0, thr});

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  cnt <= '0;
    else if (done)        cnt <= '0;
    else if (step)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tef_evtcnt.sv
module tef_evtcnt #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          inc,
  input  logic          dec,
  output logic          pending
);
  logic [CW-1:0] cnt;

  assign pending = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else begin
      case ({inc, dec})
        2'b10:   if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0)         cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/thr_evt_fifo.sv
module thr_evt_fifo #(
  parameter int DEPTH   = 64,
  parameter int DW      = 32,
  parameter int THR_W   = 8,
  parameter int SER_W   = 4,
  parameter int MAX_THR = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_tx,
  input  logic [THR_W-1:0] cfg_thresh,
  input  logic [SER_W-1:0] cfg_nser,
  input  logic             pin_rx_valid,
  output logic             pin_rx_ready,
  input  logic [DW-1:0]    pin_rx_data,
  output logic             pin_tx_valid,
  input  logic             pin_tx_ready,
  output logic [DW-1:0]    pin_tx_data,
  output logic             dma_rd_valid,
  input  logic             dma_rd_ready,
  output logic [DW-1:0]    dma_rd_data,
  input  logic             dma_wr_valid,
  output logic             dma_wr_ready,
  input  logic [DW-1:0]    dma_wr_data,
  output logic             dma_req,
  input  logic             sts_clr_ovf,
  input  logic             sts_clr_unf,
  output logic             sts_ovf,
  output logic             sts_unf,
  output logic             sts_cfg_bad
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [31:0] DEPTH_U = 32'(DEPTH);

  logic en_rx, en_tx;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic acc_push, acc_pop;
  logic pin_step, dma_step, pin_done, dma_done;
  logic [DW-1:0] fifo_wdata, fifo_rdata;
  logic [LW-1:0] fifo_level, init_cnt;

  assign en_rx = cfg_en && !cfg_tx;
  assign en_tx = cfg_en && cfg_tx;

  // Direction steering of the two stream sides onto the storage.
  assign fifo_push  = en_rx ? pin_rx_valid : (en_tx && dma_wr_valid);
  assign fifo_pop   = en_rx ? dma_rd_ready : (en_tx && pin_tx_ready);
  assign fifo_wdata = cfg_tx ? dma_wr_data : pin_rx_data;
  assign acc_push   = fifo_push && !fifo_full;
  assign acc_pop    = fifo_pop && !fifo_empty;
  assign pin_step   = cfg_tx ? acc_pop : acc_push;
  assign dma_step   = cfg_tx ? acc_push : acc_pop;

  assign pin_rx_ready = en_rx;
  assign dma_wr_ready = en_tx && !fifo_full;
  assign dma_rd_valid = en_rx && !fifo_empty;
  assign pin_tx_valid = en_tx && !fifo_empty;
  assign dma_rd_data  = fifo_rdata;
  assign pin_tx_data  = pin_tx_valid ? fifo_rdata : '0;

  // Transmit starts with every free chunk already requested.
  always_comb begin
    if (cfg_tx && cfg_thresh != '0)
      init_cnt = LW'(DEPTH_U / 32'(cfg_thresh));
    else
      init_cnt = '0;
  end

  tef_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_en),
    .push(fifo_push), .pop(fifo_pop), .wdata(fifo_wdata), .rdata(fifo_rdata),
    .full(fifo_full), .empty(fifo_empty), .level(fifo_level)
  );

  tef_chunk #(.W(THR_W)) u_pin_chunk (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_en), .step(pin_step),
    .thr(cfg_thresh), .done(pin_done)
  );

  tef_chunk #(.W(THR_W)) u_dma_chunk (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_en), .step(dma_step),
    .thr(cfg_thresh), .done(dma_done)
  );

  tef_evtcnt #(.CW(LW)) u_evt (
    .clk(clk), .rst_n(rst_n), .load(!cfg_en), .load_val(init_cnt),
    .inc(pin_done), .dec(dma_done), .pending(dma_req)
  );

  // Sticky flags: a new event in the clearing cycle wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_ovf <= 1'b0;
      sts_unf <= 1'b0;
    end else begin
      if (en_rx && pin_rx_valid && fifo_full) sts_ovf <= 1'b1;
      else if (sts_clr_ovf)                   sts_ovf <= 1'b0;
      if (en_tx && pin_tx_ready && fifo_empty) sts_unf <= 1'b1;
      else if (sts_clr_unf)                    sts_unf <= 1'b0;
    end
  end

  assign sts_cfg_bad = tef_pkg::thr_invalid(8'(cfg_thresh), 4'(cfg_nser), MAX_THR);
endmodule

// File: rtl/tef_chk.sv
module tef_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_tx,
  input logic          pin_rx_valid,
  input logic          pin_tx_ready,
  input logic          pin_tx_valid,
  input logic          dma_rd_valid,
  input logic          dma_req,
  input logic          sts_ovf,
  input logic          sts_unf,
  input logic          sts_clr_ovf,
  input logic          sts_clr_unf,
  input logic          fifo_full,
  input logic [LW-1:0] fifo_level,
  input logic          pin_done,
  input logic          dma_done
);
  a_r1_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (fifo_level == '0 && !dma_rd_valid && !pin_tx_valid));

  a_r2_set_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && pin_done && !dma_done) |=> dma_req);

  a_r4_coincident_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && dma_req && pin_done && dma_done) |=> dma_req);

  a_r7_ovf_on_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_tx && pin_rx_valid && fifo_full) |=> sts_ovf);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ovf && !sts_clr_ovf) |=> sts_ovf);

  a_r8_unf_on_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_tx && pin_tx_ready && !pin_tx_valid) |=> sts_unf);

  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_unf && !sts_clr_unf) |=> sts_unf);

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
endmodule

bind thr_evt_fifo tef_chk #(.DEPTH(DEPTH), .DW(DW), .LW($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx(cfg_tx),
  .pin_rx_valid(pin_rx_valid), .pin_tx_ready(pin_tx_ready), .pin_tx_valid(pin_tx_valid),
  .dma_rd_valid(dma_rd_valid), .dma_req(dma_req), .sts_ovf(sts_ovf), .sts_unf(sts_unf),
  .sts_clr_ovf(sts_clr_ovf), .sts_clr_unf(sts_clr_unf), .fifo_full(fifo_full),
  .fifo_level(fifo_level), .pin_done(pin_done), .dma_done(dma_done)
);

// File: tb/tb_thr_evt_fifo.sv
`timescale 1ns/1ps
module tb_thr_evt_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_tx = 1'b0;
  logic [7:0] cfg_thresh = 8'd8;
  logic [3:0] cfg_nser = 4'd1;
  logic pin_rx_valid = 1'b0, pin_tx_ready = 1'b0, dma_rd_ready = 1'b0, dma_wr_valid = 1'b0;
  logic sts_clr_ovf = 1'b0, sts_clr_unf = 1'b0;
  logic [31:0] pin_rx_data = '0, dma_wr_data = '0;
  logic pin_rx_ready, pin_tx_valid, dma_rd_valid, dma_wr_ready, dma_req;
  logic sts_ovf, sts_unf, sts_cfg_bad;
  logic [31:0] pin_tx_data, dma_rd_data;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  thr_evt_fifo dut (.*);

  // {thr[7:0], nser[3:0], words pushed[7:0], exp cfg_bad, exp req}
  localparam logic [21:0] VEC [8] = '{
    {8'd8,  4'd1, 8'd8,  1'b0, 1'b1},
    {8'd8,  4'd1, 8'd7,  1'b0, 1'b0},
    {8'd0,  4'd1, 8'd10, 1'b1, 1'b0},
    {8'd33, 4'd1, 8'd40, 1'b1, 1'b1},
    {8'd12, 4'd4, 8'd12, 1'b0, 1'b1},
    {8'd12, 4'd5, 8'd12, 1'b1, 1'b1},
    {8'd32, 4'd8, 8'd31, 1'b0, 1'b0},
    {8'd6,  4'd0, 8'd6,  1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic tx, input logic [7:0] thr, input logic [3:0] ns);
    cfg_en = 1'b0; cfg_tx = tx; cfg_thresh = thr; cfg_nser = ns;
    @(negedge clk);
    cfg_en = 1'b1;
  endtask

  task automatic push(input logic [31:0] d);
    pin_rx_valid = 1'b1; pin_rx_data = d;
    @(negedge clk);
    pin_rx_valid = 1'b0;
  endtask

  task automatic dpop(output logic [31:0] d);
    dma_rd_ready = 1'b1; d = dma_rd_data;
    @(negedge clk);
    dma_rd_ready = 1'b0;
  endtask

  task automatic both(input logic [31:0] din, output logic [31:0] dout);
    pin_rx_valid = 1'b1; pin_rx_data = din; dma_rd_ready = 1'b1; dout = dma_rd_data;
    @(negedge clk);
    pin_rx_valid = 1'b0; dma_rd_ready = 1'b0;
  endtask

  task automatic dwrite(input logic [31:0] d);
    dma_wr_valid = 1'b1; dma_wr_data = d;
    @(negedge clk);
    dma_wr_valid = 1'b0;
  endtask

  task automatic pread(output logic [31:0] d);
    pin_tx_ready = 1'b1; d = pin_tx_data;
    @(negedge clk);
    pin_tx_ready = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad_order;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset dma_req", 32'(dma_req), 0);
    chk("R1 reset rd_valid", 32'(dma_rd_valid), 0);
    chk("R1 reset tx_valid", 32'(pin_tx_valid), 0);
    chk("R7/R8 reset status", {30'd0, sts_ovf, sts_unf}, 0);

    // Table walk: R9 configuration flag and R2 request after n words
    foreach (VEC[i]) begin
      setup(1'b0, VEC[i][21:14], VEC[i][13:10]);
      for (int k = 0; k < int'(VEC[i][9:2]); k++) push(32'(k));
      chk($sformatf("R9 cfg_bad vec %0d", i), 32'(sts_cfg_bad), 32'(VEC[i][1]));
      chk($sformatf("R2 req vec %0d", i), 32'(dma_req), 32'(VEC[i][0]));
    end

    // R3 / R10: two chunks, drained by DMA
    setup(1'b0, 8'd8, 4'd2);
    for (int k = 0; k < 16; k++) push(32'h100 + 32'(k));
    bad_order = 0;
    for (int k = 0; k < 8; k++) begin dpop(d); if (d != 32'h100 + 32'(k)) bad_order++; end
    chk("R3 req after first chunk drained", 32'(dma_req), 1);
    for (int k = 8; k < 16; k++) begin dpop(d); if (d != 32'h100 + 32'(k)) bad_order++; end
    chk("R3 req after all drained", 32'(dma_req), 0);
    chk("R10 receive order", 32'(bad_order), 0);
    chk("R11 rd_valid when empty", 32'(dma_rd_valid), 0);

    // R4: same-cycle completion on both sides
    setup(1'b0, 8'd4, 4'd4);
    for (int k = 0; k < 7; k++) push(32'(k));
    for (int k = 0; k < 3; k++) dpop(d);
    both(32'd7, d);
    chk("R4 same-cycle req kept", 32'(dma_req), 1);
    chk("R10 word at coincident pop", d, 32'd3);
    // R4: DMA completion one cycle before pin completion
    for (int k = 0; k < 3; k++) dpop(d);
    for (int k = 8; k < 11; k++) push(32'(k));
    dpop(d);
    push(32'd11);
    chk("R4 staggered req re-raised", 32'(dma_req), 1);
    for (int k = 0; k < 4; k++) dpop(d);
    chk("R4 last word", d, 32'd11);
    chk("R3 req low after drain", 32'(dma_req), 0);

    // R1: disabling with data held
    for (int k = 0; k < 4; k++) push(32'(k));
    cfg_en = 1'b0;
    @(negedge clk);
    chk("R1 disable rd_valid", 32'(dma_rd_valid), 0);
    chk("R1 disable req", 32'(dma_req), 0);

    // R7 overflow
    setup(1'b0, 8'd32, 4'd1);
    for (int k = 0; k < 65; k++) push(32'h200 + 32'(k));
    chk("R7 ovf set", 32'(sts_ovf), 1);
    chk("R11 rx_ready while full", 32'(pin_rx_ready), 1);
    sts_clr_ovf = 1'b1; @(negedge clk); sts_clr_ovf = 1'b0;
    chk("R7 ovf cleared", 32'(sts_ovf), 0);
    bad_order = 0;
    for (int k = 0; k < 64; k++) begin dpop(d); if (d != 32'h200 + 32'(k)) bad_order++; end
    chk("R7 dropped word absent", 32'(bad_order), 0);
    chk("R7 req after 64 pops", 32'(dma_req), 0);

    // R5 / R6 transmit
    setup(1'b1, 8'd16, 4'd2);
    chk("R5 prefill req", 32'(dma_req), 1);
    for (int k = 0; k < 48; k++) dwrite(32'h300 + 32'(k));
    chk("R6 req after 48 writes", 32'(dma_req), 1);
    for (int k = 48; k < 64; k++) dwrite(32'h300 + 32'(k));
    chk("R6 req after 64 writes", 32'(dma_req), 0);
    chk("R11 wr_ready when full", 32'(dma_wr_ready), 0);
    bad_order = 0;
    for (int k = 0; k < 15; k++) begin pread(d); if (d != 32'h300 + 32'(k)) bad_order++; end
    chk("R6 req after 15 reads", 32'(dma_req), 0);
    pread(d); if (d != 32'h30f) bad_order++;
    chk("R6 req after 16 reads", 32'(dma_req), 1);
    for (int k = 16; k < 64; k++) begin pread(d); if (d != 32'h300 + 32'(k)) bad_order++; end
    chk("R10 transmit order", 32'(bad_order), 0);
    pin_tx_ready = 1'b1;
    #0.5;
    chk("R8 zero data on empty", pin_tx_data, 0);
    @(negedge clk);
    pin_tx_ready = 1'b0;
    chk("R8 unf set", 32'(sts_unf), 1);
    sts_clr_unf = 1'b1; @(negedge clk); sts_clr_unf = 1'b0;
    chk("R8 unf cleared", 32'(sts_unf), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule